// File: doc/BRIEF.md
# Cascadable Gated Event Counter

This block holds two 8-bit up-counters, a low one and a high one. A mode input either keeps them apart as two independent event counters, each with its own count source and gate, or joins them into one 16-bit counter in which the low byte is the less significant half and carries into the high byte.

Each counter picks its count source from three enable pulses produced by a free-running divider of the system clock (one pulse every 2, 4 or 8 cycles) or from an external asynchronous event pin. The pin passes through a two-flop synchroniser. Edge detection then turns each selected edge into a one-cycle count enable. A gate input must be high for a count to land.

A small register port lets software read both counters and an overflow status. Writing to a counter's address clears it. Overflow flags are cleared by writing 1 to them.

Top module: `evt_cnt_pair`

## Requirements
- R1: After reset both counters read 0x00 and both overflow flags read 0.
- R2: Source select (lo_src_i / hi_src_i) 00, 01 and 10 give one count per 2, 4 and 8 clock cycles of gate-high time. 11 selects the event pin.
- R3: Edge select 00 counts rising edges, 01 falling edges, 10 both edges, and 11 counts nothing. A pin change made before a clock edge shows in the counter after the third clock edge and not after the second.
- R4: While a counter's gate is low, that counter holds its value.
- R5: With mode_split_i = 0 the high counter increments in exactly the cycle the low counter wraps from 0xFF to 0x00. The high counter's own source and gate are then ignored.
- R6: With mode_split_i = 1 each counter uses its own source and gate, and a wrap of the low counter leaves the high counter unchanged.
- R7: Status register bit 0 (low overflow) sets when the low counter wraps in split mode. Bit 1 (high overflow) sets when the high counter wraps, which in cascade mode is the wrap of the 16-bit value. In cascade mode bit 0 never sets.
- R8: Writing the status register with a bit at 1 clears that flag, and a 0 bit leaves its flag unchanged.
- R9: A write to address 0 clears the low counter and a write to address 1 clears the high counter. A clear wins over a count arriving in the same cycle.
- R10: The read map is: address 0 the low counter, 1 the high counter, 2 the status {hi_ovf, lo_ovf} in bits 1:0, 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_split_i | input | 1 | 1: two 8-bit counters, 0: one 16-bit counter |
| lo_src_i | input | 2 | Low counter source select |
| lo_edge_i | input | 2 | Low counter pin edge select |
| lo_evt_i | input | 1 | Low counter asynchronous event pin |
| lo_gate_i | input | 1 | Low counter count gate |
| hi_src_i | input | 2 | High counter source select (split mode) |
| hi_edge_i | input | 2 | High counter pin edge select (split mode) |
| hi_evt_i | input | 1 | High counter asynchronous event pin |
| hi_gate_i | input | 1 | High counter count gate (split mode) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 2 | Write data, used only for the status flags |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |

## Verification
A wrong divider or synchroniser state shows in the counter value at the end of a fixed gate window or pulse train. That window is at most a few hundred cycles, and it is three clock edges for the pin latency. A broken carry path shows at the first 0xFF to 0x00 wrap of the low byte, 256 counts in. A wrong overflow flag stays wrong until it is cleared, so one status read after the wrap exposes it. The full 16-bit wrap needs 65,536 counts, which takes about 131 thousand cycles at the fastest tap.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned TAPS   = 3;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned FLAG_W = 2;

  typedef enum logic [1:0] {
    SRC_DIV2 = 2'b00,
    SRC_DIV4 = 2'b01,
    SRC_DIV8 = 2'b10,
    SRC_PIN  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    EDG_RISE = 2'b00,
    EDG_FALL = 2'b01,
    EDG_BOTH = 2'b10,
    EDG_NONE = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned TAPS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TAPS-1:0] tap_o
);
  logic [TAPS-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // tap k pulses once every 2^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_o[k] = &div_q[k:0];
  end
endmodule

// File: rtl/evt_src_tick.sv
module evt_src_tick
  import evt_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TAPS-1:0] tap_i,
  input  logic            evt_i,
  input  logic [1:0]      src_i,
  input  logic [1:0]      edge_i,
  input  logic            gate_i,
  output logic            tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall, pin_tick, src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], evt_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (edge_sel_e'(edge_i))
      EDG_RISE: pin_tick = rise;
      EDG_FALL: pin_tick = fall;
      EDG_BOTH: pin_tick = rise | fall;
      default:  pin_tick = 1'b0;
    endcase
  end

  always_comb begin
    unique case (src_sel_e'(src_i))
      SRC_DIV2: src_tick = tap_i[0];
      SRC_DIV4: src_tick = tap_i[1];
      SRC_DIV8: src_tick = tap_i[2];
      default:  src_tick = pin_tick;
    endcase
  end

  assign tick_o = src_tick & gate_i;
endmodule

// File: rtl/evt_byte_cnt.sv
module evt_byte_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_split_i,
  input  logic [1:0]        lo_src_i,
  input  logic [1:0]        lo_edge_i,
  input  logic              lo_evt_i,
  input  logic              lo_gate_i,
  input  logic [1:0]        hi_src_i,
  input  logic [1:0]        hi_edge_i,
  input  logic              hi_evt_i,
  input  logic              hi_gate_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [FLAG_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o
);
  localparam int unsigned NCH = 2;

  logic [TAPS-1:0]  tap;
  logic [NCH-1:0]   tick;
  logic [NCH-1:0]   evt_v, gate_v;
  logic [1:0]       src_v  [NCH];
  logic [1:0]       edge_v [NCH];
  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic             lo_wrap, hi_wrap, hi_inc;
  logic             lo_clr, hi_clr, stat_wr;
  logic             lo_ovf_q, hi_ovf_q;

  assign evt_v     = {hi_evt_i, lo_evt_i};
  assign gate_v    = {hi_gate_i, lo_gate_i};
  assign src_v[0]  = lo_src_i;
  assign src_v[1]  = hi_src_i;
  assign edge_v[0] = lo_edge_i;
  assign edge_v[1] = hi_edge_i;

  evt_prescaler #(.TAPS(TAPS)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_o (tap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_src
    evt_src_tick #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tap_i (tap),
      .evt_i (evt_v[c]),
      .src_i (src_v[c]),
      .edge_i(edge_v[c]),
      .gate_i(gate_v[c]),
      .tick_o(tick[c])
    );
  end

  assign lo_clr  = reg_we_i && (reg_addr_i == ADDR_LO);
  assign hi_clr  = reg_we_i && (reg_addr_i == ADDR_HI);
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);

  evt_byte_cnt #(.CNT_W(CNT_W)) u_lo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (lo_clr),
    .inc_i (tick[0]),
    .cnt_o (lo_cnt),
    .wrap_o(lo_wrap)
  );

  // cascade: carry from low byte replaces the high source
  assign hi_inc = mode_split_i ? tick[1] : lo_wrap;

  evt_byte_cnt #(.CNT_W(CNT_W)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hi_clr),
    .inc_i (hi_inc),
    .cnt_o (hi_cnt),
    .wrap_o(hi_wrap)
  );

  // set wins over a same-cycle write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_ovf_q <= 1'b0;
      hi_ovf_q <= 1'b0;
    end else begin
      if (mode_split_i && lo_wrap)        lo_ovf_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[0]) lo_ovf_q <= 1'b0;
      if (hi_wrap)                        hi_ovf_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[1]) hi_ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_LO:   reg_rdata_o = lo_cnt;
      ADDR_HI:   reg_rdata_o = hi_cnt;
      ADDR_STAT: reg_rdata_o[1:0] = {hi_ovf_q, lo_ovf_q};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_cnt_chk.sv
module evt_cnt_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_split_i,
  input logic             lo_gate_i,
  input logic             hi_gate_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [CNT_W-1:0] lo_q,
  input logic [CNT_W-1:0] hi_q,
  input logic             lo_ovf_q
);
  logic lo_clr, hi_clr;
  assign lo_clr = reg_we_i && reg_addr_i == 2'd0;
  assign hi_clr = reg_we_i && reg_addr_i == 2'd1;

  a_r9_lo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_clr |=> lo_q == '0);
  a_r9_hi_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_clr |=> hi_q == '0);
  a_r4_lo_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_gate_i && !lo_clr |=> $stable(lo_q));
  a_r6_hi_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_split_i && !hi_gate_i && !hi_clr |=> $stable(hi_q));
  a_r5_carry_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_split_i && !hi_clr && lo_q != {CNT_W{1'b1}} |=> $stable(hi_q));
  a_r7_no_lo_ovf_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_split_i && !lo_ovf_q |=> !lo_ovf_q);
endmodule

bind evt_cnt_pair evt_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_split_i(mode_split_i),
  .lo_gate_i   (lo_gate_i),
  .hi_gate_i   (hi_gate_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .lo_q        (lo_cnt),
  .hi_q        (hi_cnt),
  .lo_ovf_q    (lo_ovf_q)
);

// File: tb/tb_evt_cnt_pair.sv
module tb_evt_cnt_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       split = 1'b1;
  logic [1:0] lo_src = 2'b00, lo_edge = 2'b00, hi_src = 2'b00, hi_edge = 2'b00;
  logic       lo_evt = 1'b0, hi_evt = 1'b0, lo_gate = 1'b0, hi_gate = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [1:0] wdata = 2'b00;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_cnt_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_split_i(split),
    .lo_src_i(lo_src), .lo_edge_i(lo_edge), .lo_evt_i(lo_evt), .lo_gate_i(lo_gate),
    .hi_src_i(hi_src), .hi_edge_i(hi_edge), .hi_evt_i(hi_evt), .hi_gate_i(hi_gate),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // src, edge, gate, length (pulses for pin, cycles otherwise), expected count
  typedef struct packed {
    logic [1:0] src; logic [1:0] edg; logic gate; logic [7:0] len; logic [7:0] exp;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b1, 8'd16, 8'd8},
    '{2'b01, 2'b00, 1'b1, 8'd16, 8'd4},
    '{2'b10, 2'b00, 1'b1, 8'd16, 8'd2},
    '{2'b00, 2'b00, 1'b0, 8'd16, 8'd0},
    '{2'b11, 2'b00, 1'b1, 8'd5,  8'd5},
    '{2'b11, 2'b01, 1'b1, 8'd5,  8'd5},
    '{2'b11, 2'b10, 1'b1, 8'd4,  8'd8},
    '{2'b11, 2'b11, 1'b1, 8'd5,  8'd0},
    '{2'b11, 2'b00, 1'b0, 8'd5,  8'd0},
    '{2'b11, 2'b10, 1'b0, 8'd3,  8'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic gate_lo(input int n);
    @(negedge clk); lo_gate = 1'b1;
    repeat (n) @(negedge clk);
    lo_gate = 1'b0;
  endtask

  task automatic gate_hi(input int n);
    @(negedge clk); hi_gate = 1'b1;
    repeat (n) @(negedge clk);
    hi_gate = 1'b0;
  endtask

  task automatic pins(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lo_evt = 1'b1;
      repeat (3) @(negedge clk);
      lo_evt = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); check("R1 lo reset", v, 8'h00);
    rd(2'd1, v); check("R1 hi reset", v, 8'h00);
    rd(2'd2, v); check("R1 flags reset", v, 8'h00);
    rd(2'd3, v); check("R10 addr3 zero", v, 8'h00);

    // R2 R3 R4: vector table on the low counter, split mode
    for (int i = 0; i < NV; i++) begin
      lo_src = VECS[i].src; lo_edge = VECS[i].edg;
      wr(2'd0, 2'b00);
      if (VECS[i].src == 2'b11) begin
        @(negedge clk); lo_gate = VECS[i].gate;
        pins(int'(VECS[i].len));
        lo_gate = 1'b0;
      end else if (VECS[i].gate) begin
        gate_lo(int'(VECS[i].len));
      end else begin
        repeat (int'(VECS[i].len)) @(negedge clk);
      end
      rd(2'd0, v);
      check($sformatf("R2/R3/R4 vector %0d", i), v, VECS[i].exp);
    end

    // R3 latency: count after third edge, not after second
    lo_src = 2'b11; lo_edge = 2'b00;
    wr(2'd0, 2'b00);
    @(negedge clk); lo_gate = 1'b1; lo_evt = 1'b1;
    @(negedge clk); @(negedge clk); addr = 2'd0; #1 check("R3 two edges", rdata, 8'h00);
    @(negedge clk); #1 check("R3 three edges", rdata, 8'h01);
    lo_evt = 1'b0; repeat (4) @(negedge clk); lo_gate = 1'b0;

    // R6: high counter on its own source
    hi_src = 2'b01;
    wr(2'd0, 2'b00); wr(2'd1, 2'b00);
    gate_hi(32);
    rd(2'd1, v); check("R6 hi own source", v, 8'h08);
    rd(2'd0, v); check("R6 lo untouched", v, 8'h00);

    // R6 R7: split-mode low wrap
    lo_src = 2'b00;
    wr(2'd1, 2'b00); wr(2'd2, 2'b11);
    gate_lo(512);
    rd(2'd0, v); check("R7 lo wrapped", v, 8'h00);
    rd(2'd1, v); check("R6 hi no carry", v, 8'h00);
    rd(2'd2, v); check("R7 lo_ovf set", v, 8'h01);
    wr(2'd2, 2'b10);
    rd(2'd2, v); check("R8 zero bit keeps flag", v, 8'h01);
    wr(2'd2, 2'b01);
    rd(2'd2, v); check("R8 w1c clears", v, 8'h00);

    // R9: clear beats a coincident count, data ignored
    @(negedge clk); lo_gate = 1'b1; we = 1'b1; addr = 2'd0; wdata = 2'b11;
    @(negedge clk); @(negedge clk); we = 1'b0; #1 check("R9 lo clear priority", rdata, 8'h00);
    lo_gate = 1'b0;
    hi_src = 2'b00;
    @(negedge clk); hi_gate = 1'b1; we = 1'b1; addr = 2'd1;
    @(negedge clk); @(negedge clk); we = 1'b0; #1 check("R9 hi clear priority", rdata, 8'h00);
    hi_gate = 1'b0;

    // R5: cascade carry, high source ignored
    split = 1'b0; lo_src = 2'b00;
    wr(2'd0, 2'b00); wr(2'd1, 2'b00); wr(2'd2, 2'b11);
    hi_gate = 1'b1;
    gate_lo(510);
    rd(2'd0, v); check("R5 lo before wrap", v, 8'hFF);
    rd(2'd1, v); check("R5 hi before wrap", v, 8'h00);
    gate_lo(2);
    addr = 2'd1; #1 check("R5 hi carry", rdata, 8'h01);
    addr = 2'd0; #1 check("R5 lo wrapped", rdata, 8'h00);
    hi_gate = 1'b0;

    // R7: 16-bit wrap
    wr(2'd0, 2'b00); wr(2'd1, 2'b00);
    gate_lo(131072);
    rd(2'd0, v); check("R7 cascade lo", v, 8'h00);
    rd(2'd1, v); check("R7 cascade hi", v, 8'h00);
    rd(2'd2, v); check("R7 cascade flags", v, 8'h02);
    rd(2'd3, v); check("R10 addr3 zero", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule